// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block collects level-sensitive interrupt requests from PCI devices that sit behind two secondary bridges and steers each one onto one of 32 host interrupt lines. A request arrives as a single-cycle update strobe. The strobe carries three things:

- the device/function number of the requester,
- the interrupt pin it uses (one of four),
- the new level of that pin.

The router keeps the latest level of every line. It drives every line through a gate.

The gates are controlled in groups of four lines. Each group has one enable bit, which comes from the interrupt map registers held in the surrounding register file. A line whose group is disabled is held low. The level stored for that line is kept, and it shows again as soon as the group is enabled. All outputs are registered. Prioritising, acknowledging and vectoring the interrupts are left to the interrupt controller downstream.

Top module: `pci_irq_router`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every bit of `irq_out` is 0. Every stored level is also 0.
- R2: An update is routed to line index = 16*devfn[0] + 4*devfn[4:3] + pin. Slot field devfn[4:3] selects a block of four consecutive lines. Bit 0 of devfn selects the upper half (lines 16 to 31).
- R3: devfn bits 7:5 and 2:1 have no effect on which line an update reaches.
- R4: An update with level 1 to a line whose group is enabled drives that line's output to 1 one clock after the strobe.
- R5: An update with level 0 drives that line's output to 0 one clock after the strobe.
- R6: A line whose group enable bit is 0 outputs 0 one clock after that enable value is sampled, whatever its stored level.
- R7: A line's stored level is kept while its group is disabled. The level reappears on the output one clock after the group is enabled again.
- R8: An update changes only the addressed line. All other outputs keep their value while the enables are steady.
- R9: Enable bit g (of `grp_enable[7:0]`) governs exactly lines 4g to 4g+3.
- R10: With no update strobe and steady enables, no output changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| upd_valid | input | 1 | Single-cycle strobe for an interrupt level update |
| upd_devfn | input | 8 | Device/function number of the requesting device |
| upd_pin | input | 2 | Interrupt pin index 0 to 3 |
| upd_level | input | 1 | New level of the addressed pin |
| grp_enable | input | 8 | One enable bit per group of four lines |
| irq_out | output | 32 | Gated host interrupt lines |

## Verification
The bound checker looks at every cycle for several behaviours. It checks that no line of a disabled group is ever high. It checks that a set or clear update reaches its line one clock later. It checks that an update disturbs no other line, and that the outputs stay still when there is neither an update nor an enable change.

Some behaviours only the bench scenarios can show. These are the reset value, the exact line each devfn/pin pair reaches (including the ignored devfn bits), and the group-to-line ownership. The recall of a level that was stored while its group was disabled is also shown only by the bench. The bench demonstrates these with a reference model of held levels and a queue of expected output vectors.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int unsigned PINS_PER_SLOT = 4;
  localparam int unsigned SLOTS_PER_BUS = 4;
  localparam int unsigned NUM_BUSES     = 2;
  localparam int unsigned DEVFN_W       = 8;
  localparam int unsigned PIN_W         = $clog2(PINS_PER_SLOT);
  localparam int unsigned SLOT_W        = $clog2(SLOTS_PER_BUS);
  localparam int unsigned LINES_PER_BUS = PINS_PER_SLOT * SLOTS_PER_BUS;
  localparam int unsigned NUM_LINES     = LINES_PER_BUS * NUM_BUSES;
  localparam int unsigned LINE_W        = $clog2(NUM_LINES);
  localparam int unsigned NUM_GROUPS    = NUM_LINES / PINS_PER_SLOT;
  // slot field sits at devfn[4:3]; bus selector at devfn[0]
  localparam int unsigned SLOT_LSB      = 3;
  localparam int unsigned BUS_BIT       = 0;

  typedef logic [NUM_LINES-1:0]  line_vec_t;
  typedef logic [NUM_GROUPS-1:0] grp_vec_t;
  typedef logic [LINE_W-1:0]     line_idx_t;
endpackage

// File: rtl/pirq_line_decode.sv
module pirq_line_decode
  import pirq_pkg::*;
(
  input  logic [DEVFN_W-1:0] devfn,
  input  logic [PIN_W-1:0]   pin,
  output line_idx_t          line_idx,
  output line_vec_t          line_hot
);
  logic [SLOT_W-1:0] slot;
  logic              bus_sel;

  always_comb begin
    slot     = devfn[SLOT_LSB +: SLOT_W];
    bus_sel  = devfn[BUS_BIT];
    line_idx = line_idx_t'(bus_sel) * line_idx_t'(LINES_PER_BUS)
             + line_idx_t'(slot) * line_idx_t'(PINS_PER_SLOT)
             + line_idx_t'(pin);
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_hot
    assign line_hot[i] = (line_idx == line_idx_t'(i));
  end
endmodule

// File: rtl/pirq_level_store.sv
module pirq_level_store
  import pirq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      upd_valid,
  input  line_vec_t line_hot,
  input  logic      upd_level,
  output line_vec_t held_q,
  output line_vec_t held_d
);
  line_vec_t wr_en;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign wr_en[i]  = upd_valid & line_hot[i];
    assign held_d[i] = wr_en[i] ? upd_level : held_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         held_q[i] <= 1'b0;
      else if (wr_en[i])  held_q[i] <= held_d[i];
    end
  end
endmodule

// File: rtl/pirq_gate.sv
module pirq_gate
  import pirq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  line_vec_t held_d,
  input  grp_vec_t  grp_enable,
  output line_vec_t irq_q
);
  line_vec_t mask;
  line_vec_t irq_d;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_mask
    assign mask[i] = grp_enable[i / PINS_PER_SLOT];
  end

  always_comb irq_d = held_d & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end
endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
  import pirq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  upd_valid,
  input  logic [DEVFN_W-1:0]    upd_devfn,
  input  logic [PIN_W-1:0]      upd_pin,
  input  logic                  upd_level,
  input  logic [NUM_GROUPS-1:0] grp_enable,
  output logic [NUM_LINES-1:0]  irq_out
);
  line_idx_t line_idx;
  line_vec_t line_hot;
  line_vec_t held_q;
  line_vec_t held_d;

  pirq_line_decode u_dec (
    .devfn    (upd_devfn),
    .pin      (upd_pin),
    .line_idx (line_idx),
    .line_hot (line_hot)
  );

  pirq_level_store u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_valid (upd_valid),
    .line_hot  (line_hot),
    .upd_level (upd_level),
    .held_q    (held_q),
    .held_d    (held_d)
  );

  pirq_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .held_d     (held_d),
    .grp_enable (grp_enable),
    .irq_q      (irq_out)
  );
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk
  import pirq_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  upd_valid,
  input logic [DEVFN_W-1:0]    upd_devfn,
  input logic [PIN_W-1:0]      upd_pin,
  input logic                  upd_level,
  input logic [NUM_GROUPS-1:0] grp_enable,
  input logic [NUM_LINES-1:0]  irq_out
);
  logic [NUM_LINES-1:0] en_mask;
  logic [LINE_W-1:0]    tgt;
  logic [NUM_LINES-1:0] tgt_hot;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_m
    assign en_mask[i] = grp_enable[i >> 2];
  end
  assign tgt     = {upd_devfn[0], upd_devfn[4:3], upd_pin};
  assign tgt_hot = NUM_LINES'(1) << tgt;

  // R6: disabled groups never show a high line
  assert_gate_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irq_out & ~$past(en_mask)) == '0));

  // R4: enabled set reaches its line next cycle
  assert_set_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_level && en_mask[tgt]) |=> irq_out[$past(tgt)]);

  // R5: clear reaches its line next cycle
  assert_clear_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_level) |=> !irq_out[$past(tgt)]);

  // R8: other lines untouched by an update
  assert_isolated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && $stable(grp_enable)) |=>
      (((irq_out ^ $past(irq_out)) & ~$past(tgt_hot)) == '0));

  // R10: quiet cycles keep outputs
  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_valid && $stable(grp_enable)) |=> $stable(irq_out));
endmodule

bind pci_irq_router pirq_router_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .upd_valid  (upd_valid),
  .upd_devfn  (upd_devfn),
  .upd_pin    (upd_pin),
  .upd_level  (upd_level),
  .grp_enable (grp_enable),
  .irq_out    (irq_out)
);

// File: tb/pci_irq_router_test.sv
module pci_irq_router_test;
  logic        clk;
  logic        rst_n;
  logic        upd_valid;
  logic [7:0]  upd_devfn;
  logic [1:0]  upd_pin;
  logic        upd_level;
  logic [7:0]  grp_enable;
  logic [31:0] irq_out;

  int checks = 0;
  int errors = 0;
  logic [31:0] model_held = '0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 0;

  pci_irq_router uut (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_devfn(upd_devfn),
    .upd_pin(upd_pin), .upd_level(upd_level), .grp_enable(grp_enable),
    .irq_out(irq_out)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  function automatic int line_of(logic [7:0] d, logic [1:0] p);
    return ((d & 8'h18) >> 1) + p + (d[0] ? 16 : 0);
  endfunction

  function automatic logic [31:0] expand(logic [7:0] e);
    logic [31:0] m;
    for (int i = 0; i < 32; i++) m[i] = e[i/4];
    return m;
  endfunction

  task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, expected vector into the scoreboard
  task automatic step(logic v, logic [7:0] d, logic [1:0] p, logic l,
                      logic [7:0] e, string tag);
    @(negedge clk);
    upd_valid = v; upd_devfn = d; upd_pin = p; upd_level = l; grp_enable = e;
    if (v) model_held[line_of(d, p)] = l;
    @(posedge clk);
    #1;
    exp_q.push_back(model_held & expand(e));
    tag_q.push_back(tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) check(irq_out, exp_q.pop_front(), tag_q.pop_front());
  end

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; upd_valid = 0; upd_devfn = 0; upd_pin = 0; upd_level = 0;
    grp_enable = 8'hff;
    repeat (3) @(posedge clk);
    #1 check(irq_out, 32'h0, "R1 in reset");
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1 check(irq_out, 32'h0, "R1 after reset");

    step(1, 8'h00, 2'd0, 1, 8'hff, "R4 set line 0");
    step(1, 8'h18, 2'd3, 1, 8'hff, "R2 line 15");
    step(1, 8'h19, 2'd2, 1, 8'hff, "R2 line 30");
    step(1, 8'hE9, 2'd1, 1, 8'hff, "R3 masked devfn to line 21");
    step(1, 8'h26, 2'd1, 1, 8'hff, "R3 devfn 0x26 to line 1");
    step(1, 8'h00, 2'd0, 0, 8'hff, "R5 clear line 0");
    step(0, 8'h00, 2'd0, 0, 8'h7f, "R6 group 7 disabled");
    step(1, 8'h19, 2'd1, 1, 8'h7f, "R6 set while disabled");
    step(0, 8'h00, 2'd0, 0, 8'h7f, "R7 held while disabled");
    step(0, 8'h00, 2'd0, 0, 8'hff, "R7 recall on re-enable");
    repeat (4) step(0, 8'hA5, 2'd3, 1, 8'hff, "R10 idle");

    for (int i = 0; i < 32; i++) begin
      logic [7:0] d;
      d = {3'b000, 1'b0, i[3:2], 2'b00} | {7'b0, i[4]};
      d = {3'b000, i[3:2], 2'b00, i[4]};
      step(1, d, i[1:0], 1, 8'hff, "R8 sweep set");
    end
    for (int g = 0; g < 8; g++) begin
      step(0, 8'h00, 2'd0, 0, ~(8'h01 << g), "R9 single group off");
      step(0, 8'h00, 2'd0, 0, 8'hff, "R9 group back on");
    end
    for (int i = 31; i >= 0; i -= 3) begin
      step(1, {3'b111, i[3:2], 2'b11, i[4]}, i[1:0], 0, 8'h55, "R8 sweep clear");
    end
    step(0, 8'h00, 2'd0, 0, 8'hff, "R7 recall all");

    @(negedge clk); @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule